// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Sensor Reader

This block runs one measurement cycle on a single open-drain line shared with a remote sensor. The sensor reports several channels as one train of high and low pulses. On a start request the block pulls the line low for a fixed number of clocks and then lets it go, so that an external pull-up returns it high. After a settle delay it clears a free-running tick counter and arms edge capture. From then on, every transition of the line in either direction stores the counter value in a small timestamp buffer.

The framing is fixed. The arming moment supplies entry 0 of the buffer, which is always zero. The first two captured edges bound the sensor's ready marker. Each channel then contributes two more edges: one ends its high period and the next ends its low period. Once the buffer is full, the block subtracts adjacent entries for every channel and publishes a high duration and a low duration per channel, together with a one-cycle done pulse. If the sensor goes quiet, a timeout ends the attempt with an error flag and leaves the earlier results in place. Turning the durations into resistance or temperature is left to the consumer.

Top module: `pwsense_reader`

## Requirements
- R1: After reset, busy, done, err and line_pull_low are 0 and every result field is 0.
- R2: A start request seen while idle raises busy in the next cycle. It also drives line_pull_low high for exactly DRIVE_CYC (default 100) clock cycles. line_pull_low is never 1 while busy is 0.
- R3: A start request while busy is 1 has no effect: the line is not pulled low again and the measurement in progress completes with its own results.
- R4: After arming, rising and falling edges of line_in count alike. The first two captured edges frame the marker. For channel c (0-based), the high time is the tick count between captured edge 2c+2 and edge 2c+3, and the low time is the count between edge 2c+3 and edge 2c+4. One tick is TICK_DIV clocks (default 1). Channel c's high time appears on high_ticks[16c+15:16c] and its low time on low_ticks[16c+15:16c].
- R5: Durations are 16-bit unsigned differences taken modulo 65536, so they stay correct when the tick counter wraps inside a frame.
- R6: done is a single-cycle pulse, and busy is 0 in that cycle. high_ticks and low_ticks change only in a cycle where done is 1.
- R7: If TIMEOUT_TICKS ticks pass after arming or after the last captured edge with no new edge, the attempt ends. done pulses with err at 1, and the results keep their previous values.
- R8: Line transitions during the drive-low and settle phases are not captured and do not shift the edge framing.
- R9: A measurement that completes normally clears err in its done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Measurement request, acted on only while idle |
| busy | output | 1 | A measurement is in progress |
| done | output | 1 | One-cycle pulse at the end of a measurement |
| err | output | 1 | Last measurement ended by timeout |
| line_pull_low | output | 1 | Enable for the open-drain low driver on the sensor line |
| line_in | input | 1 | Sampled level of the sensor line (asynchronous) |
| high_ticks | output | 16*CHANNELS | Per-channel high durations, channel c at bits 16c+15:16c |
| low_ticks | output | 16*CHANNELS | Per-channel low durations, channel c at bits 16c+15:16c |

## Verification
Frames are driven with ascending, all-equal and mixed short and long durations, including 4-clock pulses. These show whether each channel's high and low slots are taken from the right pair of edges and kept apart from the marker and from neighbouring channels. One frame uses 15000-tick gaps so that the counter wraps part-way through. Equal results before and after the wrap separate modulo subtraction from any comparison of absolute stamps. A frame with glitches inside the settle window checks that early edges do not shift the framing. A frame with a start request injected mid-marker checks that no second drive-low occurs. A frame cut short after three channel edges must raise err and keep the prior results, and the normal frame after it must clear err.

// File: rtl/pwsense_pkg.sv
package pwsense_pkg;

    // Timestamp and duration width is fixed by the capture format.
    localparam int TS_W = 16;

    typedef logic [TS_W-1:0] stamp_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DRIVE,
        PH_SETTLE,
        PH_CAPTURE,
        PH_PUBLISH
    } phase_e;

    typedef struct packed {
        stamp_t hi;
        stamp_t lo;
    } chan_span_t;

    // Modulo-2^16 interval between two stamps.
    function automatic stamp_t span(input stamp_t later, input stamp_t earlier);
        return later - earlier;
    endfunction

endpackage

// File: rtl/pws_sync_edge.sv
module pws_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic toggled
);
    logic [STAGES-1:0] chain;
    logic              last;

    // Reset to the pulled-up idle level so no edge appears after reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            last  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
            last  <= chain[STAGES-1];
        end
    end

    assign toggled = chain[STAGES-1] ^ last;
endmodule

// File: rtl/pws_tick_timer.sv
module pws_tick_timer
    import pwsense_pkg::*;
#(
    parameter int TICK_DIV = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    output logic   tick,
    output stamp_t count
);
    localparam int DIV_W = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);

    generate
        if (TICK_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_prescale
            logic [DIV_W-1:0] pre;
            always_ff @(posedge clk) begin
                if (rst || !run)
                    pre <= '0;
                else if (pre == DIV_W'(TICK_DIV - 1))
                    pre <= '0;
                else
                    pre <= pre + 1'b1;
            end
            assign tick = run && (pre == DIV_W'(TICK_DIV - 1));
        end
    endgenerate

    // Held at zero while stopped, so arming always starts from zero.
    always_ff @(posedge clk) begin
        if (rst || !run)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/pws_span_calc.sv
module pws_span_calc
    import pwsense_pkg::*;
#(
    parameter int CHANNELS = 4,
    localparam int NUM_TS  = 2 * CHANNELS + 3
) (
    input  stamp_t     stamps [NUM_TS],
    output chan_span_t spans  [CHANNELS]
);
    // Entries 0 and 1 (arming, marker start) are not part of any channel.
    generate
        for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
            assign spans[c].hi = span(stamps[2*c+3], stamps[2*c+2]);
            assign spans[c].lo = span(stamps[2*c+4], stamps[2*c+3]);
        end
    endgenerate
endmodule

// File: rtl/pwsense_reader.sv
module pwsense_reader
    import pwsense_pkg::*;
#(
    parameter int CHANNELS      = 4,
    parameter int TICK_DIV      = 1,
    parameter int DRIVE_CYC     = 100,
    parameter int SETTLE_CYC    = 100,
    parameter int TIMEOUT_TICKS = 60000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic                     line_pull_low,
    input  logic                     line_in,
    output logic [CHANNELS*TS_W-1:0] high_ticks,
    output logic [CHANNELS*TS_W-1:0] low_ticks
);
    localparam int NUM_TS = 2 * CHANNELS + 3;
    localparam int IDX_W  = $clog2(NUM_TS + 1);
    localparam int PH_MAX = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int QT_W   = $clog2(TIMEOUT_TICKS + 1);

    phase_e           st;
    logic [PH_W-1:0]  ph_cnt;
    logic [IDX_W-1:0] idx;
    logic [QT_W-1:0]  quiet;
    logic             pull_q;
    logic             done_q;
    logic             err_q;
    logic             line_edge;
    logic             tick;
    stamp_t           now;
    stamp_t           stamps [NUM_TS];
    chan_span_t       spans  [CHANNELS];
    logic [CHANNELS*TS_W-1:0] hi_q;
    logic [CHANNELS*TS_W-1:0] lo_q;

    pws_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .din     (line_in),
        .toggled (line_edge)
    );

    pws_tick_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (st == PH_CAPTURE),
        .tick  (tick),
        .count (now)
    );

    pws_span_calc #(.CHANNELS(CHANNELS)) u_calc (
        .stamps (stamps),
        .spans  (spans)
    );

    // Timestamp buffer: wiped on every accepted start, so entry 0 is the
    // zero the counter holds at arming.
    always_ff @(posedge clk) begin
        if (rst || (st == PH_IDLE && start)) begin
            for (int i = 0; i < NUM_TS; i++)
                stamps[i] <= '0;
        end else if (st == PH_CAPTURE && line_edge) begin
            stamps[idx] <= now;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PH_IDLE;
            ph_cnt <= '0;
            idx    <= '0;
            quiet  <= '0;
            pull_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            hi_q   <= '0;
            lo_q   <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                PH_IDLE: begin
                    if (start) begin
                        st     <= PH_DRIVE;
                        ph_cnt <= '0;
                        pull_q <= 1'b1;
                    end
                end
                PH_DRIVE: begin
                    if (ph_cnt == PH_W'(DRIVE_CYC - 1)) begin
                        st     <= PH_SETTLE;
                        ph_cnt <= '0;
                        pull_q <= 1'b0;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                PH_SETTLE: begin
                    if (ph_cnt == PH_W'(SETTLE_CYC - 1)) begin
                        st    <= PH_CAPTURE;
                        idx   <= IDX_W'(1);
                        quiet <= '0;
                    end else begin
                        ph_cnt <= ph_cnt + 1'b1;
                    end
                end
                PH_CAPTURE: begin
                    if (line_edge) begin
                        quiet <= '0;
                        idx   <= idx + 1'b1;
                        if (idx == IDX_W'(NUM_TS - 1))
                            st <= PH_PUBLISH;
                    end else if (tick) begin
                        if (quiet == QT_W'(TIMEOUT_TICKS - 1)) begin
                            st     <= PH_IDLE;
                            done_q <= 1'b1;
                            err_q  <= 1'b1;
                        end else begin
                            quiet <= quiet + 1'b1;
                        end
                    end
                end
                PH_PUBLISH: begin
                    for (int c = 0; c < CHANNELS; c++) begin
                        hi_q[c*TS_W +: TS_W] <= spans[c].hi;
                        lo_q[c*TS_W +: TS_W] <= spans[c].lo;
                    end
                    done_q <= 1'b1;
                    err_q  <= 1'b0;
                    st     <= PH_IDLE;
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

    assign busy          = (st != PH_IDLE);
    assign done          = done_q;
    assign err           = err_q;
    assign line_pull_low = pull_q;
    assign high_ticks    = hi_q;
    assign low_ticks     = lo_q;
endmodule

// File: rtl/pwsense_reader_chk.sv
module pwsense_reader_chk #(
    parameter int CHANNELS  = 4,
    parameter int DRIVE_CYC = 100
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic                   err,
    input logic                   line_pull_low,
    input logic [CHANNELS*16-1:0] high_ticks,
    input logic [CHANNELS*16-1:0] low_ticks
);
    int pull_run;

    always_ff @(posedge clk) begin
        if (rst)
            pull_run <= 0;
        else if (line_pull_low)
            pull_run <= pull_run + 1;
        else
            pull_run <= 0;
    end

    a_r2_pull_only_busy: assert property (@(posedge clk) disable iff (rst)
        line_pull_low |-> busy);

    a_r2_start_accepted: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && line_pull_low));

    a_r2_drive_length: assert property (@(posedge clk) disable iff (rst)
        $fell(line_pull_low) |-> (pull_run == DRIVE_CYC));

    a_r3_no_second_drive: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> !$rose(line_pull_low));

    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r6_results_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(high_ticks) && $stable(low_ticks)));

    a_r7_err_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    a_r7_err_keeps_results: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> ($stable(high_ticks) && $stable(low_ticks)));

    a_r9_err_clear_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(err) |-> done);
endmodule

bind pwsense_reader pwsense_reader_chk #(
    .CHANNELS  (CHANNELS),
    .DRIVE_CYC (DRIVE_CYC)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .line_pull_low (line_pull_low),
    .high_ticks    (high_ticks),
    .low_ticks     (low_ticks)
);

// File: tb/pwsense_reader_tb.sv
module pwsense_reader_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CH         = 4;
    localparam int TMO        = 20000;
    localparam int DRV        = 100;
    localparam int NUMV       = 4;

    // Entry 0: marker low length; entries 1..8: ch0 hi, ch0 lo, ch1 hi, ...
    typedef int vec_t [9];
    localparam vec_t VEC [NUMV] = '{
        '{40,   10,   20,  30,   40,  50,  60,   70,   80},
        '{5,     4,    4,   4,    4,   4,   4,    4,    4},
        '{200, 1000, 250,  17,  900, 400, 400,    4, 1234},
        '{60,  1200,   7,   9, 1500, 333,  44, 5000,   12}
    };
    localparam vec_t WRAPV = '{50, 15000, 15000, 15000, 15000, 15000, 20, 30, 40};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic sens_lvl = 1'b1;
    logic busy, done, err, pull, line_in;
    logic [CH*16-1:0] hi, lo;
    logic [CH*16-1:0] hold_hi, hold_lo;
    int checks = 0;
    int fails = 0;
    int last_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign line_in = pull ? 1'b0 : sens_lvl;

    pwsense_reader #(.TIMEOUT_TICKS(TMO)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .busy          (busy),
        .done          (done),
        .err           (err),
        .line_pull_low (pull),
        .line_in       (line_in),
        .high_ticks    (hi),
        .low_ticks     (lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_results(input string req, input vec_t d);
        for (int c = 0; c < CH; c++) begin
            chk(req, 32'(hi[c*16 +: 16]), 32'(d[1+2*c]));
            chk(req, 32'(lo[c*16 +: 16]), 32'(d[2+2*c]));
        end
    endtask

    // One measurement: start, drive-low check, sensor frame, wait for done.
    task automatic run_frame(input vec_t d, input int n_edges,
                             input bit poke, input bit glitch, output int err_seen);
        int  plen;
        bit  got;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R2 busy after start", 32'(busy), 1);
        plen = 0;
        while (pull) begin
            plen++;
            @(negedge clk);
        end
        chk("R2 drive-low length", plen, DRV);
        if (glitch) begin
            // R8: transitions inside the settle window
            repeat (30) @(negedge clk);
            sens_lvl = 1'b0;
            repeat (5) @(negedge clk);
            sens_lvl = 1'b1;
            repeat (115) @(negedge clk);
        end else begin
            repeat (150) @(negedge clk);
        end
        sens_lvl = 1'b0;
        if (poke) begin
            // R3: start while busy; R6: results unchanged mid-frame
            @(negedge clk) start = 1'b1;
            @(negedge clk) start = 1'b0;
            chk("R3 no drive on busy start", 32'(pull), 0);
            chk("R6 results held mid-frame", 32'(hi[15:0]), 32'(hold_hi[15:0]));
            repeat (d[0] - 2) @(negedge clk);
        end else begin
            repeat (d[0]) @(negedge clk);
        end
        sens_lvl = 1'b1;
        for (int k = 0; k < n_edges; k++) begin
            repeat (d[k+1]) @(negedge clk);
            sens_lvl = ~sens_lvl;
        end
        got = 1'b0;
        for (int w = 0; w < TMO + 300 && !got; w++) begin
            @(negedge clk);
            if (done) got = 1'b1;
        end
        chk("R6 done seen", 32'(got), 1);
        chk("R6 busy low with done", 32'(busy), 0);
        err_seen = int'(err);
        @(negedge clk);
        chk("R6 done single cycle", 32'(done), 0);
        sens_lvl = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 pull", 32'(pull), 0);
        chk("R1 high", 32'(hi[31:0]), 0);
        chk("R1 low", 32'(lo[31:0]), 0);

        // R4 table of frames
        for (int v = 0; v < NUMV; v++) begin
            run_frame(VEC[v], 8, 1'b0, 1'b0, last_err);
            chk("R4 no err", last_err, 0);
            chk_results("R4 durations", VEC[v]);
        end

        // R5 counter wraps inside the frame
        run_frame(WRAPV, 8, 1'b0, 1'b0, last_err);
        chk("R5 no err", last_err, 0);
        chk_results("R5 wrap durations", WRAPV);

        // R3 start during busy, R8 settle glitch
        hold_hi = hi;
        hold_lo = lo;
        run_frame(VEC[0], 8, 1'b1, 1'b1, last_err);
        chk_results("R3 R8 durations", VEC[0]);

        // R7 timeout: only 3 channel edges
        hold_hi = hi;
        hold_lo = lo;
        run_frame(VEC[2], 3, 1'b0, 1'b0, last_err);
        chk("R7 err on timeout", last_err, 1);
        chk("R7 high kept", 32'(hi[31:0]), 32'(hold_hi[31:0]));
        chk("R7 high kept", 32'(hi[63:32]), 32'(hold_hi[63:32]));
        chk("R7 low kept", 32'(lo[31:0]), 32'(hold_lo[31:0]));
        chk("R7 low kept", 32'(lo[63:32]), 32'(hold_lo[63:32]));

        // R9 next good frame clears err
        run_frame(VEC[3], 8, 1'b0, 1'b0, last_err);
        chk("R9 err cleared", last_err, 0);
        chk_results("R9 durations", VEC[3]);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule